// File: doc/BRIEF.md
# Page Permission and Fault Status Checker

This block sits after a page-table walk and rules on whether one data access may proceed. It takes the leaf attribute bits of a completed translation and the kind of access (load or store, privileged or user). From these it either grants the access or raises a fault. When the walker reports that no translation exists, the checker still produces the fault, adding the store flag to the no-translation code. On a fault it builds a status word and a faulting address. For an access that runs off the end of a mapped page into an unmapped one, the faulting address is the start of the following page.

A small state machine handles one request at a time. In `PS_IDLE` it accepts a request and captures it. In `PS_CHECK` it evaluates the captured request. From there it moves to `PS_GRANT` or `PS_FAULT`, which each present a one-cycle response, and then returns to `PS_IDLE`. The transitions are `PS_IDLE -> PS_CHECK` on an accepted request, `PS_CHECK -> PS_GRANT` when the access is allowed, `PS_CHECK -> PS_FAULT` when it is refused, and `PS_GRANT/PS_FAULT -> PS_IDLE` unconditionally.

A sticky status/address register pair holds the most recent fault. Software may overwrite either register, for example to clear it. A grant never disturbs the pair.

Top module: `pgchk_top`

## Requirements
- R1: After reset `req_ready` is 1, `rsp_valid` is 0, and `fault_stat` and `fault_addr` are 0.
- R2: A request is accepted when `req_valid` and `req_ready` are both 1 at a clock edge. `req_ready` is 0 for the next two cycles. The response (`rsp_valid`=1) appears for exactly one cycle, in the second cycle after acceptance.
- R3: If `req_nomap`=1, the access faults with status 0x40000000, or 0x42000000 for a store. The address is `req_ea`.
- R4: If `req_nomap`=1 and `req_miss_hi`=1, the fault address is `req_ea` with its low 12 bits cleared, plus 0x1000.
- R5: Attribute bit 2 (mask 0x004) grants read and bit 1 (0x002) grants write. A load without read, or a store without write, faults with status 0x08000000. A store also ORs in the store flag 0x02000000, giving 0x0a000000.
- R6: If attribute bit 3 (0x008, privileged page) is set and `req_priv`=0, the access faults with the permission status of R5.
- R7: Attribute bit 8 (0x100) is referenced and bit 7 (0x080) is changed. A permitted load with referenced clear faults with 0x00040000. A permitted store with changed or referenced clear faults with 0x02040000.
- R8: Checks are applied in a fixed order: no-translation first, then permission, then referenced/changed. Only the first failing class appears in the status; for example, a load to attribute 0x000 reports 0x08000000 and not 0x08040000.
- R9: A load with read and referenced set is granted (`rsp_ok`=1) whatever the changed bit holds. `rsp_nc` then shows attribute bit 5 (0x020, non-cacheable).
- R10: `fault_stat`/`fault_addr` change only on a fault or a software write. A grant leaves them unchanged.
- R11: `sw_we_stat` loads `sw_wdata[31:0]` into `fault_stat` and `sw_we_addr` loads `sw_wdata` into `fault_addr`. If a fault is recorded on the same edge, the fault values win.
- R12: On a fault, `rsp_ok` is 0 and `rsp_fault` is 1, so neither the load result nor the store may commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Checker idle, request may be accepted |
| req_store | input | 1 | 1 = store, 0 = load |
| req_priv | input | 1 | 1 = privileged access |
| req_ea | input | AW | Effective address of the access |
| req_attr | input | 9 | Leaf attribute bits of the translation |
| req_nomap | input | 1 | Walker found no translation |
| req_miss_hi | input | 1 | Missing translation is for the next page of a crossing access |
| sw_we_stat | input | 1 | Software write of the status register |
| sw_we_addr | input | 1 | Software write of the address register |
| sw_wdata | input | AW | Software write data |
| rsp_valid | output | 1 | Verdict present |
| rsp_ok | output | 1 | Access granted |
| rsp_fault | output | 1 | Access refused |
| rsp_nc | output | 1 | Granted page is non-cacheable |
| fault_stat | output | 32 | Sticky fault status |
| fault_addr | output | AW | Sticky fault address |

## Verification
Some properties are checked on every cycle. These are the handshake timing of acceptance and response, the single-cycle response width, and the exclusivity of grant and fault. They also cover the rule that the sticky pair moves only on a fault or a software write, and the rule that no status ever mixes two fault classes. The bench scenarios are needed for the rest. Those are the exact status values for each attribute pattern, the next-page address on a crossing miss, the privileged-page case, the non-cacheable indication, and the fault-beats-software collision.

// File: rtl/pgchk_pkg.sv
package pgchk_pkg;
    localparam int STAT_W = 32;
    localparam int ATTR_W = 9;

    localparam logic [STAT_W-1:0] FS_NOXLATE = 32'h4000_0000;
    localparam logic [STAT_W-1:0] FS_DENIED  = 32'h0800_0000;
    localparam logic [STAT_W-1:0] FS_STORE   = 32'h0200_0000;
    localparam logic [STAT_W-1:0] FS_REFCHG  = 32'h0004_0000;

    localparam int AB_WR   = 1;
    localparam int AB_RD   = 2;
    localparam int AB_PRIV = 3;
    localparam int AB_NC   = 5;
    localparam int AB_CHG  = 7;
    localparam int AB_REF  = 8;

    typedef enum logic [1:0] {
        PS_IDLE,
        PS_CHECK,
        PS_GRANT,
        PS_FAULT
    } pstate_e;

    typedef struct packed {
        logic              store;
        logic              priv;
        logic [ATTR_W-1:0] attr;
        logic              nomap;
        logic              miss_hi;
    } req_ctl_t;
endpackage

// File: rtl/perm_judge.sv
module perm_judge
    import pgchk_pkg::*;
#(
    parameter int AW = 64,
    parameter int PG = 12
) (
    input  req_ctl_t           ctl,
    input  logic [AW-1:0]      ea,
    output logic               ok,
    output logic [STAT_W-1:0]  stat,
    output logic [AW-1:0]      addr
);
    localparam int VW = AW - PG;

    logic [VW-1:0]     vpn_next;
    logic [STAT_W-1:0] st_bit;
    logic              may_access;
    logic              rc_good;

    assign vpn_next   = ea[AW-1:PG] + 1'b1;
    assign st_bit     = ctl.store ? FS_STORE : '0;
    assign may_access = (ctl.store ? ctl.attr[AB_WR] : ctl.attr[AB_RD])
                        && !(ctl.attr[AB_PRIV] && !ctl.priv);
    assign rc_good    = ctl.attr[AB_REF] && (!ctl.store || ctl.attr[AB_CHG]);

    always_comb begin
        ok   = 1'b0;
        stat = '0;
        addr = ea;
        if (ctl.nomap) begin
            stat = FS_NOXLATE | st_bit;
            if (ctl.miss_hi)
                addr = {vpn_next, {PG{1'b0}}};
        end else if (!may_access) begin
            stat = FS_DENIED | st_bit;
        end else if (!rc_good) begin
            stat = FS_REFCHG | st_bit;
        end else begin
            ok = 1'b1;
        end
    end
endmodule

// File: rtl/fault_regs.sv
module fault_regs
    import pgchk_pkg::*;
#(
    parameter int AW = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hw_load,
    input  logic [STAT_W-1:0] hw_stat,
    input  logic [AW-1:0]     hw_addr,
    input  logic              sw_we_stat,
    input  logic              sw_we_addr,
    input  logic [AW-1:0]     sw_wdata,
    output logic [STAT_W-1:0] stat_q,
    output logic [AW-1:0]     addr_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
            addr_q <= '0;
        end else if (hw_load) begin
            stat_q <= hw_stat;
            addr_q <= hw_addr;
        end else begin
            if (sw_we_stat) stat_q <= sw_wdata[STAT_W-1:0];
            if (sw_we_addr) addr_q <= sw_wdata;
        end
    end
endmodule

// File: rtl/pgchk_top.sv
module pgchk_top
    import pgchk_pkg::*;
#(
    parameter int AW = 64,
    parameter int PG = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_store,
    input  logic              req_priv,
    input  logic [AW-1:0]     req_ea,
    input  logic [8:0]        req_attr,
    input  logic              req_nomap,
    input  logic              req_miss_hi,
    input  logic              sw_we_stat,
    input  logic              sw_we_addr,
    input  logic [AW-1:0]     sw_wdata,
    output logic              rsp_valid,
    output logic              rsp_ok,
    output logic              rsp_fault,
    output logic              rsp_nc,
    output logic [31:0]       fault_stat,
    output logic [AW-1:0]     fault_addr
);
    pstate_e           state_q, state_d;
    req_ctl_t          ctl_q;
    logic [AW-1:0]     ea_q;
    logic              v_ok;
    logic [STAT_W-1:0] v_stat;
    logic [AW-1:0]     v_addr;
    logic              rec_fault;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PS_IDLE;
        else        state_q <= state_d;
    end

    // request capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
            ea_q  <= '0;
        end else if (state_q == PS_IDLE && req_valid) begin
            ctl_q <= '{store: req_store, priv: req_priv, attr: req_attr,
                       nomap: req_nomap, miss_hi: req_miss_hi};
            ea_q  <= req_ea;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_IDLE:  if (req_valid) state_d = PS_CHECK;
            PS_CHECK: state_d = v_ok ? PS_GRANT : PS_FAULT;
            PS_GRANT: state_d = PS_IDLE;
            PS_FAULT: state_d = PS_IDLE;
            default:  state_d = PS_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_ready = 1'b0;
        rsp_valid = 1'b0;
        rsp_ok    = 1'b0;
        rsp_fault = 1'b0;
        rsp_nc    = 1'b0;
        rec_fault = 1'b0;
        unique case (state_q)
            PS_IDLE:  req_ready = 1'b1;
            PS_CHECK: rec_fault = !v_ok;
            PS_GRANT: begin
                rsp_valid = 1'b1;
                rsp_ok    = 1'b1;
                rsp_nc    = ctl_q.attr[AB_NC];
            end
            PS_FAULT: begin
                rsp_valid = 1'b1;
                rsp_fault = 1'b1;
            end
            default: ;
        endcase
    end

    perm_judge #(.AW(AW), .PG(PG)) u_judge (
        .ctl  (ctl_q),
        .ea   (ea_q),
        .ok   (v_ok),
        .stat (v_stat),
        .addr (v_addr)
    );

    fault_regs #(.AW(AW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .hw_load    (rec_fault),
        .hw_stat    (v_stat),
        .hw_addr    (v_addr),
        .sw_we_stat (sw_we_stat),
        .sw_we_addr (sw_we_addr),
        .sw_wdata   (sw_wdata),
        .stat_q     (fault_stat),
        .addr_q     (fault_addr)
    );
endmodule

// File: rtl/pgchk_props.sv
module pgchk_props #(
    parameter int AW = 64
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_ready,
    input logic          sw_we_stat,
    input logic          rsp_valid,
    input logic          rsp_ok,
    input logic          rsp_fault,
    input logic [31:0]   fault_stat,
    input logic [AW-1:0] fault_addr
);
    // R2
    accept_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (!req_ready ##1 rsp_valid));

    // R2
    single_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R12
    verdict_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_ok != rsp_fault));

    // R10
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(fault_stat) |-> (rsp_fault || $past(sw_we_stat)));

    // R8
    one_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> ($countones({fault_stat[30], fault_stat[27], fault_stat[18]}) == 1));

    // R12
    resp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);

    logic unused_addr;
    assign unused_addr = ^fault_addr;
endmodule

bind pgchk_top pgchk_props #(.AW(AW)) u_props (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .sw_we_stat (sw_we_stat),
    .rsp_valid  (rsp_valid),
    .rsp_ok     (rsp_ok),
    .rsp_fault  (rsp_fault),
    .fault_stat (fault_stat),
    .fault_addr (fault_addr)
);

// File: tb/pgchk_tb.sv
module pgchk_top_tb_top;
    localparam int AW = 64;

    logic          clk = 0;
    logic          rst_n = 0;
    logic          req_valid = 0, req_store = 0, req_priv = 0;
    logic [AW-1:0] req_ea = '0;
    logic [8:0]    req_attr = '0;
    logic          req_nomap = 0, req_miss_hi = 0;
    logic          sw_we_stat = 0, sw_we_addr = 0;
    logic [AW-1:0] sw_wdata = '0;
    logic          req_ready, rsp_valid, rsp_ok, rsp_fault, rsp_nc;
    logic [31:0]   fault_stat;
    logic [AW-1:0] fault_addr;

    always #4 clk = ~clk;

    pgchk_top #(.AW(AW)) dut_i (.*);

    typedef struct {
        logic          ok;
        logic          nc;
        logic [31:0]   stat;
        logic [AW-1:0] addr;
        string         tag;
    } exp_t;

    exp_t          sb_q[$];
    int            n_chk = 0, n_fail = 0;
    logic [31:0]   m_stat = '0;
    logic [AW-1:0] m_addr = '0;
    bit            done = 0;

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic chk(input bit good, input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        n_chk++;
        if (!good) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pop and compare each response
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (sb_q.size() == 0) begin
                chk(0, "R2 unexpected response", 1, 0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                chk(rsp_ok == e.ok && rsp_fault == !e.ok, {e.tag, " verdict"}, {62'b0, rsp_fault, rsp_ok}, {62'b0, !e.ok, e.ok});
                chk(rsp_nc == e.nc, {e.tag, " nc"}, {63'b0, rsp_nc}, {63'b0, e.nc});
                chk(fault_stat == e.stat, {e.tag, " status"}, {32'b0, fault_stat}, {32'b0, e.stat});
                chk(fault_addr == e.addr, {e.tag, " address"}, fault_addr, e.addr);
            end
        end
    end

    // driver: issue one request, push expected item
    task automatic issue(input bit st, input bit pv, input logic [AW-1:0] ea, input logic [8:0] at,
                         input bit nm, input bit hi, input bit collide,
                         input bit e_ok, input bit e_nc, input logic [31:0] e_stat,
                         input logic [AW-1:0] e_addr, input string tag);
        exp_t e;
        @(negedge clk);
        req_valid = 1; req_store = st; req_priv = pv; req_ea = ea; req_attr = at;
        req_nomap = nm; req_miss_hi = hi;
        if (!e_ok) begin m_stat = e_stat; m_addr = e_addr; end
        e.ok = e_ok; e.nc = e_nc; e.stat = m_stat; e.addr = m_addr; e.tag = tag;
        sb_q.push_back(e);
        @(posedge clk); #1;
        req_valid = 0;
        chk(req_ready == 0, "R2 busy after accept", {63'b0, req_ready}, 0);
        if (collide) begin
            sw_we_stat = 1; sw_we_addr = 1; sw_wdata = 64'h5555_5555_5555;
        end
        @(posedge clk); #1;
        sw_we_stat = 0; sw_we_addr = 0;
        @(negedge clk);
        chk(rsp_valid == 1, "R2 response timing", {63'b0, rsp_valid}, 1);
    endtask

    task automatic sw_write(input logic [AW-1:0] d);
        @(negedge clk);
        sw_we_stat = 1; sw_we_addr = 1; sw_wdata = d;
        @(posedge clk); #1;
        sw_we_stat = 0; sw_we_addr = 0;
        m_stat = d[31:0]; m_addr = d;
        @(negedge clk);
        chk(fault_stat == m_stat && fault_addr == m_addr, "R11 software write", fault_addr, m_addr);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=hung expected=done");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(req_ready == 1 && rsp_valid == 0, "R1 reset handshake", {62'b0, req_ready, rsp_valid}, 2);
        chk(fault_stat == 0 && fault_addr == 0, "R1 reset registers", fault_addr, 0);

        // R3 no translation, load and store
        issue(0, 1, 64'h123000, 9'h000, 1, 0, 0, 0, 0, 32'h4000_0000, 64'h123000, "R3 load nomap");
        issue(1, 1, 64'h123008, 9'h000, 1, 0, 0, 0, 0, 32'h4200_0000, 64'h123008, "R3 store nomap");
        // R4 page-crossing miss
        issue(0, 1, 64'h39fffd, 9'h186, 1, 1, 0, 0, 0, 32'h4000_0000, 64'h3a0000, "R4 load cross");
        issue(1, 1, 64'h39fffd, 9'h186, 1, 1, 0, 0, 0, 32'h4200_0000, 64'h3a0000, "R4 store cross");
        // R9 / R10 grant leaves registers
        issue(0, 1, 64'h124108, 9'h186, 0, 0, 0, 1, 0, 0, 0, "R10 grant full perms");
        issue(0, 1, 64'h124000, 9'h106, 0, 0, 0, 1, 0, 0, 0, "R9 load ref no chg");
        // R7 referenced/changed
        issue(1, 1, 64'h124000, 9'h106, 0, 0, 0, 0, 0, 32'h0204_0000, 64'h124000, "R7 store no chg");
        issue(0, 1, 64'h124010, 9'h006, 0, 0, 0, 0, 0, 32'h0004_0000, 64'h124010, "R7 load no ref");
        issue(1, 1, 64'h124018, 9'h006, 0, 0, 0, 0, 0, 32'h0204_0000, 64'h124018, "R7 store no rc");
        // R5 / R8 permission before R/C
        issue(0, 1, 64'h124020, 9'h100, 0, 0, 0, 0, 0, 32'h0800_0000, 64'h124020, "R5 load no read");
        issue(1, 1, 64'h124028, 9'h104, 0, 0, 0, 0, 0, 32'h0a00_0000, 64'h124028, "R5 store no write");
        issue(0, 1, 64'h124030, 9'h000, 0, 0, 0, 0, 0, 32'h0800_0000, 64'h124030, "R8 perm over rc");
        issue(1, 1, 64'h124038, 9'h1ff, 1, 0, 0, 0, 0, 32'h4200_0000, 64'h124038, "R8 nomap first");
        // R6 privileged page
        issue(0, 0, 64'h125000, 9'h18e, 0, 0, 0, 0, 0, 32'h0800_0000, 64'h125000, "R6 user on priv");
        issue(1, 1, 64'h125008, 9'h18e, 0, 0, 0, 1, 0, 0, 0, "R6 priv on priv");
        // R9 non-cacheable indication
        issue(0, 0, 64'h126000, 9'h1a6, 0, 0, 0, 1, 1, 0, 0, "R9 nc grant");
        // R11 software clear then grant keeps zero (R10)
        sw_write(64'h0);
        issue(0, 0, 64'h127000, 9'h186, 0, 0, 0, 1, 0, 0, 0, "R10 grant after clear");
        sw_write(64'h0000_00ab_cdef_0123);
        // R11 fault wins over a same-edge software write; R12 no commit
        issue(1, 0, 64'h128040, 9'h184, 0, 0, 1, 0, 0, 32'h0a00_0000, 64'h128040, "R11 collision");

        repeat (3) @(negedge clk);
        chk(sb_q.size() == 0, "R2 all responses seen", sb_q.size(), 0);
        done = 1;
        finish_run();
    end
endmodule